// File: doc/BRIEF.md
# Signed-Aware Adder/Subtractor with Flags

This block is an N-bit ripple-carry adder (4 bits by default) that also subtracts. Subtraction does not alter the adder chain. The B operand is complemented and the incoming borrow is inverted before the chain. The carry leaving the chain is then inverted to give the outgoing borrow. The same carry/borrow pin serves both modes, so wider words are built by feeding one word's carry/borrow output into the next word's carry/borrow input.

Besides the N-bit result and the carry/borrow, the block reports the following flags:
- **Sign:** the result MSB.
- **Zero:** all result bits are clear.
- **Signed overflow:** the XOR of the carry entering the sign stage and the carry leaving it.
- **Less:** overflow XOR sign.

The less flag is the sign of the exact result seen as an (N+1)-bit signed number. That number is also provided as an extended result, formed as the less bit on top of the N result bits. All outputs are registered one clock after the inputs. A synchronous active-high reset clears them.

Top module: `sgn_addsub`

## Requirements
- R1: With op_sub=0, one cycle after the inputs are sampled, res_q = (A + B + cb_in) mod 2^N and cb_q is the carry out of the MSB stage.
- R2: With op_sub=1, res_q = (A - B - cb_in) mod 2^N. Here cb_in=1 means a borrow is pending. cb_q is the borrow out, which is 1 exactly when A < B + cb_in taken as unsigned.
- R3: ovf_q is the XOR of the carries into and out of the sign stage. It is 1 exactly when A and the effective B (B inverted when op_sub=1) have the same sign and the result sign differs from them. On 4 bits, 0111+0001 gives 1000 with cb_q=0, sign_q=1, ovf_q=1. 1000+0000 gives 1000 with cb_q=0, sign_q=1, ovf_q=0.
- R4: sign_q equals the MSB of the result.
- R5: zero_q is 1 exactly when all N result bits are 0, whatever cb_q is.
- R6: less_q equals the sign of the exact signed result (A+B+cb_in, or A-B-cb_in). In subtraction, it is 1 exactly when signed A < signed B + cb_in.
- R7: ext_q = {less_q, res_q} is the exact signed result in N+1 bits, covering -2^N to 2^N-1. On 8 bits, 0xC0+0x90 gives res_q=0x50, ovf_q=1, sign_q=0 and ext_q=-176.
- R8: In addition with cb_in=1, B=0111 (4 bits) acts as +8, so ovf_q=1 exactly when A is non-negative. B=1111 returns A unchanged, with cb_q=1 and ovf_q=0.
- R9: Two N-bit operations chained by feeding cb_q into cb_in give the correct 2N-bit sum or difference. The upper word's ovf_q is the 2N-bit signed overflow.
- R10: Outputs change only at a rising clk edge, one cycle after the inputs. While rst=1 at an edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | N | Operand A |
| b_in | input | N | Operand B |
| cb_in | input | 1 | Carry in (add) or borrow in (subtract) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| res_q | output | N | Registered N-bit result |
| cb_q | output | 1 | Carry out (add) or borrow out (subtract) |
| sign_q | output | 1 | Sign flag |
| zero_q | output | 1 | Zero flag |
| ovf_q | output | 1 | Signed overflow flag |
| less_q | output | 1 | Overflow XOR sign |
| ext_q | output | N+1 | Exact signed result in N+1 bits |

## Verification
The bench builds two copies: one at the default N=4 and one at N=8. The 4-bit copy makes an exhaustive sweep of every operand, carry/borrow and mode combination feasible. The sweep compares each output with integer arithmetic, including the +8 and full-circle cases with carry set. The 4-bit copy also carries the two-word chaining runs that produce 8-bit sums and differences. The 8-bit copy reaches the wide-operand overflow case, whose extended result lies below -128.

// File: rtl/sgn_addsub_pkg.sv
package sgn_addsub_pkg;
  typedef struct packed {
    logic cb;
    logic sign;
    logic zero;
    logic ovf;
    logic less;
  } flags_t;
endpackage

// File: rtl/sas_operand_prep.sv
module sas_operand_prep #(
  parameter int N = 4
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         cb_in,
  input  logic         op_sub,
  output logic [N-1:0] x_o,
  output logic [N-1:0] y_o,
  output logic         ci_o
);
  // Subtraction feeds NOT B and NOT borrow into the unchanged chain.
  for (genvar i = 0; i < N; i++) begin : g_inv
    assign y_o[i] = b_in[i] ^ op_sub;
  end
  assign x_o  = a_in;
  assign ci_o = cb_in ^ op_sub;
endmodule

// File: rtl/sas_ripple_core.sv
module sas_ripple_core #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [N:0] c;
  assign c[0] = ci;
  for (genvar i = 0; i < N; i++) begin : g_cell
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
  end
  assign c_into_msb = c[N-1];
  assign c_out      = c[N];
endmodule

// File: rtl/sas_flag_gen.sv
module sas_flag_gen
  import sgn_addsub_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] s,
  input  logic         c_into_msb,
  input  logic         c_out,
  input  logic         op_sub,
  output flags_t       f,
  output logic [N:0]   ext
);
  always_comb begin
    f.cb   = c_out ^ op_sub;
    f.sign = s[N-1];
    f.zero = ~|s;
    f.ovf  = c_out ^ c_into_msb;
    f.less = f.ovf ^ f.sign;
    ext    = {f.less, s};
  end
endmodule

// File: rtl/sgn_addsub.sv
module sgn_addsub
  import sgn_addsub_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         cb_in,
  input  logic         op_sub,
  output logic [N-1:0] res_q,
  output logic         cb_q,
  output logic         sign_q,
  output logic         zero_q,
  output logic         ovf_q,
  output logic         less_q,
  output logic [N:0]   ext_q
);
  logic [N-1:0] x, y, s;
  logic         ci, c_msb, c_out;
  flags_t       f;
  logic [N:0]   ext;

  sas_operand_prep #(.N(N)) u_prep (
    .a_in(a_in), .b_in(b_in), .cb_in(cb_in), .op_sub(op_sub),
    .x_o(x), .y_o(y), .ci_o(ci)
  );

  sas_ripple_core #(.N(N)) u_core (
    .x(x), .y(y), .ci(ci), .s(s), .c_into_msb(c_msb), .c_out(c_out)
  );

  sas_flag_gen #(.N(N)) u_flags (
    .s(s), .c_into_msb(c_msb), .c_out(c_out), .op_sub(op_sub),
    .f(f), .ext(ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      cb_q   <= 1'b0;
      sign_q <= 1'b0;
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
      less_q <= 1'b0;
      ext_q  <= '0;
    end else begin
      res_q  <= s;
      cb_q   <= f.cb;
      sign_q <= f.sign;
      zero_q <= f.zero;
      ovf_q  <= f.ovf;
      less_q <= f.less;
      ext_q  <= ext;
    end
  end
endmodule

// File: rtl/sgn_addsub_chk.sv
module sgn_addsub_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] a_in,
  input logic [N-1:0] b_in,
  input logic         cb_in,
  input logic         op_sub,
  input logic [N-1:0] res_q,
  input logic         cb_q,
  input logic         sign_q,
  input logic         zero_q,
  input logic         ovf_q,
  input logic         less_q,
  input logic [N:0]   ext_q
);
  logic [N:0] add_u, sub_u, res_u, a_x, b_x, c_x, wide_ref;
  logic       ovf_ref;

  always_comb begin
    c_x      = {{N{1'b0}}, cb_in};
    add_u    = {1'b0, a_in} + {1'b0, b_in} + c_x;
    sub_u    = {1'b0, a_in} - {1'b0, b_in} - c_x;
    res_u    = op_sub ? sub_u : add_u;
    a_x      = {a_in[N-1], a_in};
    b_x      = {b_in[N-1], b_in};
    wide_ref = op_sub ? (a_x - b_x - c_x) : (a_x + b_x + c_x);
    ovf_ref  = (a_in[N-1] == (b_in[N-1] ^ op_sub)) && (res_u[N-1] != a_in[N-1]);
  end

  assert_add_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_sub)) |-> (res_q == $past(add_u[N-1:0]) && cb_q == $past(add_u[N])));

  assert_sub_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sub)) |-> (res_q == $past(sub_u[N-1:0]) && cb_q == $past(sub_u[N])));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ovf_q == $past(ovf_ref)));

  assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sign_q == $past(res_u[N-1])));

  assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (zero_q == ($past(res_u[N-1:0]) == '0)));

  assert_less_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (less_q == $past(wide_ref[N])));

  assert_ext_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ext_q == $past(wide_ref)));

  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && !cb_q && !sign_q && !zero_q && !ovf_q && !less_q && ext_q == '0));
endmodule

bind sgn_addsub sgn_addsub_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cb_in(cb_in), .op_sub(op_sub),
  .res_q(res_q), .cb_q(cb_q), .sign_q(sign_q), .zero_q(zero_q), .ovf_q(ovf_q),
  .less_q(less_q), .ext_q(ext_q)
);

// File: tb/sim_sgn_addsub.sv
module sim_sgn_addsub;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic [3:0] a, b, r;
  logic       ci, sb, cbo, sg, zr, ov, ls;
  logic [4:0] ex;
  logic [7:0] a8, b8, r8;
  logic       ci8, sb8, cbo8, sg8, zr8, ov8, ls8;
  logic [8:0] ex8;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sgn_addsub #(.N(4)) u0 (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .cb_in(ci), .op_sub(sb),
    .res_q(r), .cb_q(cbo), .sign_q(sg), .zero_q(zr), .ovf_q(ov), .less_q(ls), .ext_q(ex)
  );

  sgn_addsub #(.N(8)) u8 (
    .clk(clk), .rst(rst), .a_in(a8), .b_in(b8), .cb_in(ci8), .op_sub(sb8),
    .res_q(r8), .cb_q(cbo8), .sign_q(sg8), .zero_q(zr8), .ovf_q(ov8), .less_q(ls8), .ext_q(ex8)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic run4(input int av, input int bv, input int cv, input int sv);
    @(negedge clk);
    a = av[3:0]; b = bv[3:0]; ci = cv[0]; sb = sv[0];
    @(negedge clk);
  endtask

  task automatic test_reset();
    rst = 1'b1; a = 4'hF; b = 4'hF; ci = 1'b1; sb = 1'b0;
    a8 = 8'hFF; b8 = 8'hFF; ci8 = 1'b1; sb8 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset res", int'(r), 0);
    chk("R10 reset cb", int'(cbo), 0);
    chk("R10 reset flags", int'({sg, zr, ov, ls}), 0);
    chk("R10 reset ext", int'(ex), 0);
    chk("R10 reset ext8", int'(ex8), 0);
    rst = 1'b0;
  endtask

  task automatic test_latency();
    run4(3, 4, 0, 0);
    @(negedge clk);
    a = 4'd1; b = 4'd1; ci = 1'b0; sb = 1'b0;
    #1;
    chk("R10 hold before edge", int'(r), 7);
    @(negedge clk);
    chk("R10 update after edge", int'(r), 2);
  endtask

  task automatic test_exhaustive();
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++) begin
            int t, y, cy, si, sj, ws;
            si = (i >= 8) ? i - 16 : i;
            sj = (j >= 8) ? j - 16 : j;
            if (s == 0) begin
              t = i + j + c; y = t & 15; cy = (t >> 4) & 1; ws = si + sj + c;
            end else begin
              t = i - j - c; y = t & 15; cy = (t < 0) ? 1 : 0; ws = si - sj - c;
            end
            run4(i, j, c, s);
            chk(s == 0 ? "R1 sum" : "R2 diff", int'(r), y);
            chk(s == 0 ? "R1 carry" : "R2 borrow", int'(cbo), cy);
            chk("R3 ovf", int'(ov), (ws > 7 || ws < -8) ? 1 : 0);
            chk("R4 sign", int'(sg), (y >> 3) & 1);
            chk("R5 zero", int'(zr), (y == 0) ? 1 : 0);
            chk("R6 less", int'(ls), (ws < 0) ? 1 : 0);
            chk("R7 ext", int'(ex), ws & 31);
          end
  endtask

  task automatic test_examples();
    run4(7, 1, 0, 0);
    chk("R3 7+1 res", int'(r), 8);
    chk("R3 7+1 cb", int'(cbo), 0);
    chk("R3 7+1 sign", int'(sg), 1);
    chk("R3 7+1 ovf", int'(ov), 1);
    run4(8, 0, 0, 0);
    chk("R3 -8+0 res", int'(r), 8);
    chk("R3 -8+0 cb", int'(cbo), 0);
    chk("R3 -8+0 ovf", int'(ov), 0);
    run4(8, 8, 0, 0);
    chk("R5 zero with carry", int'(zr), 1);
    chk("R5 carry set", int'(cbo), 1);
  endtask

  task automatic test_carry_set();
    for (int i = 0; i < 16; i++) begin
      run4(i, 7, 1, 0);
      chk("R8 plus eight ovf", int'(ov), (i < 8) ? 1 : 0);
      chk("R8 plus eight res", int'(r), (i + 8) & 15);
      run4(i, 15, 1, 0);
      chk("R8 full circle res", int'(r), i);
      chk("R8 full circle cb", int'(cbo), 1);
      chk("R8 full circle ovf", int'(ov), 0);
    end
  endtask

  task automatic test_chain();
    int xs[6] = '{8'h7F, 8'h01, 8'h80, 8'hC3, 8'h3C, 8'hFF};
    int ys[6] = '{8'h01, 8'hFF, 8'h01, 8'h9A, 8'h44, 8'hFF};
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 6; k++) begin
        int x, y, lo, hi, cy, sx, sy, ws, full;
        x = xs[k]; y = ys[k];
        run4(x & 15, y & 15, 0, s);
        lo = int'(r); cy = int'(cbo);
        run4((x >> 4) & 15, (y >> 4) & 15, cy, s);
        hi = int'(r);
        sx = (x >= 128) ? x - 256 : x;
        sy = (y >= 128) ? y - 256 : y;
        ws = (s == 0) ? sx + sy : sx - sy;
        full = (s == 0) ? (x + y) & 255 : (x - y) & 255;
        chk("R9 chained word", (hi << 4) | lo, full);
        chk("R9 chained ovf", int'(ov), (ws > 127 || ws < -128) ? 1 : 0);
      end
  endtask

  task automatic test_wide8();
    @(negedge clk);
    a8 = 8'hC0; b8 = 8'h90; ci8 = 1'b0; sb8 = 1'b0;
    @(negedge clk);
    chk("R7 8-bit res", int'(r8), 8'h50);
    chk("R7 8-bit ovf", int'(ov8), 1);
    chk("R7 8-bit sign", int'(sg8), 0);
    chk("R7 8-bit ext", int'(ex8), (-176) & 511);
    chk("R6 8-bit less", int'(ls8), 1);
  endtask

  initial begin
    test_reset();
    test_latency();
    test_exhaustive();
    test_examples();
    test_carry_set();
    test_chain();
    test_wide8();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule